// File: doc/BRIEF.md
# I2C Serial EEPROM Slave (2K x 8)

This block is an I2C target that behaves like a 2048-byte serial EEPROM with an on-chip byte array. A fast system clock samples the SCL and SDA wires through two-flop synchronizers. The block drives SDA only through an open-drain enable: when `sda_oe` is 1 the pad pulls the line low, and when it is 0 the line is released. A single 11-bit address pointer serves both reads and writes. After any access it holds the address of the last byte touched plus one.

A write transfer sends a write-type device byte, then a word address byte, then zero or more data bytes. The word address byte loads the pointer. Each data byte is stored at the pointer, and the pointer then advances. A read transfer either continues from the pointer (current-address read) or follows a write-type prefix that only sets the pointer (random read, using a repeated start). The master keeps a read going by acknowledging each byte. The pointer wraps from the top of the array to address 0.

The controller is a state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_DEV`: receiving the device byte.
- `ST_DEV_ACK`: acknowledging the device byte.
- `ST_WADDR`: receiving the word address.
- `ST_WADDR_ACK`: acknowledging the word address.
- `ST_WDATA`: receiving a write data byte.
- `ST_WDATA_ACK`: acknowledging a write data byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RACK`: sampling the master's acknowledge.
- `ST_SKIP`: ignoring the bus until the next start or stop.

Its transitions are:
- Any state goes to `ST_DEV` on a start, and to `ST_IDLE` on a stop.
- `ST_DEV` goes to `ST_DEV_ACK` when the prefix matches, and to `ST_SKIP` when it does not.
- `ST_DEV_ACK` goes to `ST_RDATA` or `ST_WADDR`, according to the R/W bit.
- `ST_WADDR` goes to `ST_WADDR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, then back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK`.
- `ST_RACK` goes to `ST_RDATA` on a master ACK, and to `ST_SKIP` on a master NACK.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, and while the bus stays idle, `sda_oe` is 0 (SDA released).
- R2: Device byte layout: bit 0 is R/W (1 = read, 0 = write), bits 3:1 are the upper three address bits, and bits 7:4 must equal 1010. On a match the slave pulls SDA low in the ninth clock. On a mismatch it never drives SDA until the next start.
- R3: In a write, the word address byte sets the pointer to {device bits 3:1, word byte}. Each following data byte is acknowledged, stored at the pointer, and the pointer then advances by one.
- R4: A current-address read acknowledges the device byte and returns the byte at the full 11-bit pointer, with no word address phase.
- R5: A random read is a write-type device byte, then a word address, then a repeated start with a read-type device byte. It returns the byte at that address.
- R6: A master ACK after a read byte makes the slave send the byte at the next address. A master NACK ends the read and leaves SDA released until the next start.
- R7: The read pointer spans all 11 bits. After address 2047 it continues at address 0 and keeps serving bytes.
- R8: A start at any point aborts the transfer in progress. A partly received data byte is not stored, and decoding restarts with a device byte.
- R9: The slave changes its SDA drive only while SCL is low. It samples data and ACK bits at the rising edge of SCL.
- R10: A stop ends any transfer and releases SDA. Data written before the stop is readable at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level (resolved bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Assertions check several properties on every cycle:
- the ACK or skip decision that follows each device byte;
- the pointer advancing by one on every stored byte and on every acknowledged read byte;
- a start always returning the machine to device decoding, and a stop always idling it with SDA released;
- the SDA drive rising only while the synchronized SCL is low.

Only the bench's bus scenarios can show the returned data itself. These scenarios cover:
- the pointer's continuity across separate transfers;
- the wrap from 2047 to 0;
- a repeated start that leaves a half-received byte unwritten;
- read-back of the pseudo-random write and read mix against a shadow memory.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

    localparam int           PREFIX_W   = 4;
    localparam logic [3:0]   DEV_PREFIX = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } ctrl_state_t;

endpackage

// File: rtl/i2c_eeprom_sync.sv
module i2c_eeprom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains reset to the idle (high) bus level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    // SDA edges while SCL stays high mark bus conditions
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_eeprom_array.sv
module i2c_eeprom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/i2c_eeprom_ctrl.sv
module i2c_eeprom_ctrl
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sda_oe
);
    localparam int             BLK_W    = ADDR_W - DATA_W;
    localparam int             CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(1);

    ctrl_state_t       st;
    ctrl_state_t       st_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [ADDR_W-1:0] ptr;
    logic [BLK_W-1:0]  blk;
    logic              acked;
    logic              byte_done;
    logic              ack_done;
    logic              is_rx;
    logic              load_rd;

    assign byte_done = scl_fall && (bit_cnt == BYTE_END);
    assign ack_done  = scl_fall && (bit_cnt == ACK_END);
    assign is_rx     = (st == ST_DEV) || (st == ST_WADDR) || (st == ST_WDATA);
    assign load_rd   = (st_nx == ST_RDATA) && (st != ST_RDATA);

    // Next-state decision; bus conditions override everything
    always_comb begin
        st_nx = st;
        if (start_det) begin
            st_nx = ST_DEV;
        end else if (stop_det) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:      st_nx = ST_IDLE;
                ST_SKIP:      st_nx = ST_SKIP;
                ST_DEV:       if (byte_done)
                                  st_nx = (rx_sh[DATA_W-1 -: PREFIX_W] == DEV_PREFIX)
                                          ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:   if (ack_done) st_nx = rx_sh[0] ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) st_nx = ST_WADDR_ACK;
                ST_WADDR_ACK: if (ack_done) st_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) st_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ack_done) st_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) st_nx = ST_RACK;
                ST_RACK:      if (ack_done) st_nx = acked ? ST_RDATA : ST_SKIP;
                default:      st_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Shift registers, bit counter and address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '1;
            ptr     <= '0;
            blk     <= '0;
            acked   <= 1'b0;
        end else begin
            if (start_det || (st_nx != st)) begin
                bit_cnt <= '0;
            end else if (scl_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (scl_rise && is_rx) begin
                rx_sh <= {rx_sh[DATA_W-2:0], sda_lvl};
            end

            if (scl_rise && (st == ST_RACK)) begin
                acked <= ~sda_lvl;
            end

            if ((st == ST_DEV) && byte_done) begin
                blk <= rx_sh[BLK_W:1];
            end

            if ((st == ST_WADDR) && byte_done) begin
                ptr <= {blk, rx_sh};
            end else if (mem_we) begin
                ptr <= ptr + 1'b1;
            end else if (load_rd) begin
                ptr <= ptr + 1'b1;
            end

            if (load_rd) begin
                tx_sh <= mem_rdata;
            end else if ((st == ST_RDATA) && scl_fall && (bit_cnt != '0)
                         && (bit_cnt != BYTE_END)) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (st)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                               sda_oe = ~tx_sh[DATA_W-1];
            default:                                sda_oe = 1'b0;
        endcase
    end

    assign mem_we    = (st == ST_WDATA) && byte_done;
    assign mem_addr  = ptr;
    assign mem_wdata = rx_sh;

    // R2
    prefix_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DEV) && byte_done && (rx_sh[DATA_W-1 -: PREFIX_W] == DEV_PREFIX))
        |=> (st == ST_DEV_ACK))
        else $error("prefix_ack_chk");

    // R2
    prefix_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DEV) && byte_done && (rx_sh[DATA_W-1 -: PREFIX_W] != DEV_PREFIX))
        |=> ((st == ST_SKIP) && !sda_oe))
        else $error("prefix_reject_chk");

    // R3
    write_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr == $past(ptr) + 1'b1))
        else $error("write_advance_chk");

    // R7
    read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RACK) && ack_done && acked && !start_det && !stop_det)
        |=> (ptr == $past(ptr) + 1'b1))
        else $error("read_advance_chk");

    // R6
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RACK) && ack_done && !acked) |=> ((st == ST_SKIP) && !sda_oe))
        else $error("nack_release_chk");

    // R8
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> ((st == ST_DEV) && (bit_cnt == '0)))
        else $error("start_restart_chk");

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> ((st == ST_IDLE) && !sda_oe))
        else $error("stop_idle_chk");

    // R9
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl)
        else $error("oe_rise_low_chk");

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    i2c_eeprom_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_eeprom_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .sda_oe    (sda_oe)
    );

    i2c_eeprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_eeprom_slave i_i2c_eeprom_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    int          checks  = 0;
    int          fails   = 0;
    int          oe_viol = 0;
    bit          done    = 1'b0;
    logic        oe_d    = 1'b0;
    logic [7:0]  model [2048];
    bit          valid [2048];
    logic [10:0] mptr    = '0;

    // R9 monitor: drive changes seen while SCL is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_d) && scl_m) oe_viol++;
        oe_d <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        wait_clk(Q); sda_m = b;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(Q); s = sda_line;
        wait_clk(Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wait_clk(Q); sda_m = 1'b1;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(2 * Q); sda_m = 1'b0;
        wait_clk(2 * Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(Q); sda_m = 1'b0;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(2 * Q); sda_m = 1'b1;
        wait_clk(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = (s == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            d[i] = s;
        end
        bit_cycle(!give_ack, s);
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] blk, input bit rd);
        return {4'b1010, blk, rd};
    endfunction

    task automatic read_seq(input int n, input string req);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            if (valid[mptr]) check(d === model[mptr], (k == 0) ? req : "R6",
                                   "read data", int'(d), int'(model[mptr]));
            mptr = mptr + 11'd1;
        end
        wait_clk(Q);
        check(sda_oe == 1'b0, "R6", "SDA released after NACK", int'(sda_oe), 0);
        bus_stop();
        check(sda_oe == 1'b0, "R10", "SDA released after stop", int'(sda_oe), 0);
    endtask

    task automatic do_write(input logic [10:0] a, input int n, input string req);
        bit         ack;
        logic [7:0] d;
        logic [10:0] p;
        bus_start();
        send_byte(dev_byte(a[10:8], 1'b0), ack);
        check(ack, "R2", "device ack (write)", int'(ack), 1);
        send_byte(a[7:0], ack);
        check(ack, req, "word address ack", int'(ack), 1);
        p = a;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check(ack, req, "data ack", int'(ack), 1);
            model[p] = d;
            valid[p] = 1'b1;
            p = p + 11'd1;
        end
        bus_stop();
        mptr = p;
    endtask

    task automatic do_rand_read(input logic [10:0] a, input int n, input string req);
        bit ack;
        bus_start();
        send_byte(dev_byte(a[10:8], 1'b0), ack);
        check(ack, req, "dummy write device ack", int'(ack), 1);
        send_byte(a[7:0], ack);
        check(ack, req, "dummy write address ack", int'(ack), 1);
        bus_start();
        send_byte(dev_byte(a[10:8], 1'b1), ack);
        check(ack, req, "read device ack", int'(ack), 1);
        mptr = a;
        read_seq(n, req);
    endtask

    task automatic do_cur_read(input int n, input string req);
        bit ack;
        bus_start();
        send_byte(dev_byte(3'($urandom), 1'b1), ack);
        check(ack, req, "current read device ack", int'(ack), 1);
        read_seq(n, req);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit         ack;
        logic       s;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) valid[i] = 1'b0;

        // R1: reset state and idle bus
        wait_clk(5);
        check(sda_oe == 1'b0, "R1", "sda_oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        wait_clk(40);
        check(sda_oe == 1'b0, "R1", "sda_oe idle after reset", int'(sda_oe), 0);

        // R3: fill the low region and the top of the array
        for (int b = 0; b < 5; b++) do_write(11'(b * 16), 16, "R3");
        do_write(11'd2044, 4, "R3");

        // R2: mismatching prefix is never acknowledged
        bus_start();
        send_byte(8'hB0, ack);
        check(!ack, "R2", "bad prefix ack", int'(ack), 0);
        send_byte(8'h00, ack);
        check(!ack, "R2", "silent after bad prefix", int'(ack), 0);
        bus_stop();

        // R5 random read, R4 current-address continuation
        do_rand_read(11'd2044, 1, "R5");
        do_cur_read(2, "R4");

        // R7: sequential read wraps from 2047 to 0
        do_rand_read(11'd2046, 5, "R7");

        // R10: written data readable right after stop
        do_write(11'd300, 1, "R10");
        do_rand_read(11'd300, 1, "R10");

        // R8: repeated start in the middle of a data byte
        bus_start();
        send_byte(dev_byte(3'd0, 1'b0), ack);
        send_byte(8'd30, ack);
        send_byte(8'h5A, ack);
        check(ack, "R8", "data ack before abort", int'(ack), 1);
        model[30] = 8'h5A; valid[30] = 1'b1;
        for (int i = 0; i < 3; i++) bit_cycle(1'b0, s);
        bus_start();
        send_byte(dev_byte(3'd0, 1'b1), ack);
        check(ack, "R8", "device ack after abort", int'(ack), 1);
        recv_byte(1'b0, d);
        check(d === model[31], "R8", "partial byte not stored", int'(d), int'(model[31]));
        bus_stop();
        do_rand_read(11'd30, 2, "R8");

        // Mixed pseudo-random traffic against the shadow model
        for (int t = 0; t < 40; t++) begin
            int op = int'($urandom_range(2, 0));
            logic [10:0] a = 11'($urandom_range(63, 0));
            int n = int'($urandom_range(4, 1));
            if (op == 0)      do_write(a, n, "R3");
            else if (op == 1) do_rand_read(a, n, "R5");
            else              do_cur_read(n, "R4");
        end

        check(oe_viol == 0, "R9", "SDA drive changes while SCL high", oe_viol, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule